// File: doc/BRIEF.md
# Bit Manipulation Execution Unit

This unit performs one scalar bit operation per request on an operand whose width is set by a parameter (32 or 64 bits). A request carries an operation code, a source word, a control word and a valid strobe. The operations are:

- counting leading zeros, trailing zeros and set bits;
- copying a bit field selected by a start and a length packed into the control word;
- three operations on the lowest set bit: isolate it, build a mask up to it, or clear it;
- clearing every bit from an index upward.

All operations are computed in one combinational stage. The result, a carry flag and a zero flag are captured in an output register. They appear with a valid flag exactly one clock after the request. Between requests the outputs keep their last values.

The operation codes are 0 leading-zero count, 1 trailing-zero count, 2 population count, 3 field extract, 4 lowest-bit isolate, 5 lowest-bit mask, 6 lowest-bit clear, 7 zero-high. XLEN below is the operand width.

Top module: `bitmanip_unit`

## Requirements
- R1: Op 0 returns the number of zero bits above the most significant 1 of the source, with carry 0; an all-zero source returns XLEN with carry 1.
- R2: Op 1 returns the number of zero bits below the least significant 1 of the source, with carry 0; an all-zero source returns XLEN with carry 1.
- R3: Op 2 returns the number of 1 bits in the source, with carry 0.
- R4: Op 3 takes the start position from control bits 7:0 and the length from control bits 15:8. Result bit i equals source bit start+i when i < length and start+i < XLEN, and is 0 otherwise. Carry is 0.
- R5: Op 3 with a length of 0, or with a start at or above XLEN, returns 0.
- R6: Op 4 returns a word in which only the lowest 1 of the source is set (0 for a zero source), with carry 0.
- R7: Op 5 sets every bit from bit 0 up to and including the lowest 1 of the source and clears the rest, with carry 0. A zero source gives all ones.
- R8: Op 6 returns the source with its lowest 1 cleared (0 for a zero source), with carry 0.
- R9: Op 7 takes an index from control bits 7:0 and clears every source bit at and above that index. When the index is below XLEN, carry is 0.
- R10: Op 7 with an index at or above XLEN returns the source unchanged with carry 1.
- R11: Result and flags appear with out_valid high exactly one clock after a cycle with in_valid high. Without a request, out_valid is low the next clock and result and flags hold.
- R12: The zero flag is 1 exactly when the registered result is 0.
- R13: During reset, out_valid, the result and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 3 | Operation code |
| in_src | input | XLEN | Source operand |
| in_ctl | input | XLEN | Control operand (start/length or index) |
| out_valid | output | 1 | Result valid, one clock after request |
| out_result | output | XLEN | Registered result |
| out_carry | output | 1 | Carry flag |
| out_zero | output | 1 | Zero flag |

## Verification
The bench targets the all-zero source for both zero counts. A design that scans off the end would return a wrong count or leave carry clear there. It probes field extraction at the upper edge of the word, with zero length, and with a start beyond the word. A design that wraps the shift or decodes length off by one returns stray bits in those cases. It checks zero-high with an index at, just below and above the width: a wrong comparator either truncates the source or misses the carry. It checks the mask and isolate operations on a zero source and on a source with only bit 0 or only the top bit set, where borrow handling usually fails. It also holds in_valid low after a request: a design that loads the register every cycle would change the result.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  typedef enum logic [2:0] {
    OP_LZC  = 3'd0,
    OP_TZC  = 3'd1,
    OP_POP  = 3'd2,
    OP_FEXT = 3'd3,
    OP_ISO  = 3'd4,
    OP_MSK  = 3'd5,
    OP_CLR  = 3'd6,
    OP_ZHI  = 3'd7
  } bmu_op_e;

  localparam int unsigned CTL_POS_LSB = 0;
  localparam int unsigned CTL_LEN_LSB = 8;
  localparam int unsigned CTL_FLD_W   = 8;
endpackage

// File: rtl/bmu_count.sv
module bmu_count #(
  parameter int unsigned XLEN = 32,
  localparam int unsigned CW = $clog2(XLEN + 1)
) (
  input  logic [XLEN-1:0] src,
  output logic [CW-1:0]   lead_cnt,
  output logic [CW-1:0]   trail_cnt,
  output logic [CW-1:0]   ones_cnt,
  output logic            src_zero
);
  // Leading zeros: the highest set bit wins, since it is assigned last.
  always_comb begin
    lead_cnt = CW'(XLEN);
    for (int i = 0; i < XLEN; i++) begin
      if (src[i]) lead_cnt = CW'(XLEN - 1 - i);
    end
  end

  // Trailing zeros: the lowest set bit wins, since it is assigned last.
  always_comb begin
    trail_cnt = CW'(XLEN);
    for (int i = XLEN - 1; i >= 0; i--) begin
      if (src[i]) trail_cnt = CW'(i);
    end
  end

  always_comb begin
    ones_cnt = '0;
    for (int i = 0; i < XLEN; i++) begin
      ones_cnt = ones_cnt + CW'(src[i]);
    end
  end

  assign src_zero = (src == '0);
endmodule

// File: rtl/bmu_lowbit.sv
module bmu_lowbit #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] src,
  output logic [XLEN-1:0] iso,
  output logic [XLEN-1:0] msk,
  output logic [XLEN-1:0] clr
);
  logic [XLEN-1:0] dec;

  // A zero source borrows all the way up, so dec is all ones.
  assign dec = src - XLEN'(1);
  assign iso = src & ~dec;
  assign msk = src ^ dec;
  assign clr = src & dec;
endmodule

// File: rtl/bmu_field.sv
module bmu_field #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] src,
  input  logic [XLEN-1:0] ctl,
  output logic [XLEN-1:0] ext,
  output logic [XLEN-1:0] zhi,
  output logic            idx_wide
);
  import bmu_pkg::*;

  logic [CTL_FLD_W-1:0] start_pos;
  logic [CTL_FLD_W-1:0] fld_len;
  logic [XLEN-1:0]      shifted;
  logic [XLEN-1:0]      len_mask;
  logic [XLEN-1:0]      keep_mask;

  assign start_pos = ctl[CTL_POS_LSB +: CTL_FLD_W];
  assign fld_len   = ctl[CTL_LEN_LSB +: CTL_FLD_W];

  // A logical shift fills with zeros, so bits past the top read as 0.
  assign shifted = src >> start_pos;

  for (genvar g = 0; g < XLEN; g++) begin : g_mask
    assign len_mask[g]  = (fld_len > CTL_FLD_W'(g));
    assign keep_mask[g] = (start_pos > CTL_FLD_W'(g));
  end

  assign ext      = shifted & len_mask;
  assign zhi      = src & keep_mask;
  assign idx_wide = (int'(start_pos) >= int'(XLEN));
endmodule

// File: rtl/bitmanip_unit.sv
module bitmanip_unit #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [2:0]      in_op,
  input  logic [XLEN-1:0] in_src,
  input  logic [XLEN-1:0] in_ctl,
  output logic            out_valid,
  output logic [XLEN-1:0] out_result,
  output logic            out_carry,
  output logic            out_zero
);
  import bmu_pkg::*;

  localparam int unsigned CW = $clog2(XLEN + 1);

  // Reset is asserted at once and released through two flops.
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic [CW-1:0]   lead_cnt, trail_cnt, ones_cnt;
  logic            src_zero;
  logic [XLEN-1:0] iso, msk, clr, ext, zhi;
  logic            idx_wide;

  bmu_count #(.XLEN(XLEN)) u_count (
    .src(in_src), .lead_cnt(lead_cnt), .trail_cnt(trail_cnt),
    .ones_cnt(ones_cnt), .src_zero(src_zero)
  );

  bmu_lowbit #(.XLEN(XLEN)) u_lowbit (
    .src(in_src), .iso(iso), .msk(msk), .clr(clr)
  );

  bmu_field #(.XLEN(XLEN)) u_field (
    .src(in_src), .ctl(in_ctl), .ext(ext), .zhi(zhi), .idx_wide(idx_wide)
  );

  // Next-state selection
  logic [XLEN-1:0] nxt_res;
  logic            nxt_carry;
  logic            nxt_zero;

  always_comb begin
    nxt_carry = 1'b0;
    unique case (bmu_op_e'(in_op))
      OP_LZC: begin nxt_res = XLEN'(lead_cnt);  nxt_carry = src_zero; end
      OP_TZC: begin nxt_res = XLEN'(trail_cnt); nxt_carry = src_zero; end
      OP_POP:  nxt_res = XLEN'(ones_cnt);
      OP_FEXT: nxt_res = ext;
      OP_ISO:  nxt_res = iso;
      OP_MSK:  nxt_res = msk;
      OP_CLR:  nxt_res = clr;
      OP_ZHI: begin
        nxt_res   = idx_wide ? in_src : zhi;
        nxt_carry = idx_wide;
      end
      default: nxt_res = '0;
    endcase
    nxt_zero = (nxt_res == '0);
  end

  // Output register, loaded only on an accepted request
  logic            vld_q;
  logic [XLEN-1:0] res_q;
  logic            carry_q;
  logic            zero_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q   <= 1'b0;
      res_q   <= '0;
      carry_q <= 1'b0;
      zero_q  <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        res_q   <= nxt_res;
        carry_q <= nxt_carry;
        zero_q  <= nxt_zero;
      end
    end
  end

  assign out_valid  = vld_q;
  assign out_result = res_q;
  assign out_carry  = carry_q;
  assign out_zero   = zero_q;
endmodule

// File: rtl/bmu_checker.sv
module bmu_checker #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [2:0]      in_op,
  input logic [XLEN-1:0] in_src,
  input logic [XLEN-1:0] in_ctl,
  input logic            out_valid,
  input logic [XLEN-1:0] out_result,
  input logic            out_carry,
  input logic            out_zero
);
  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R11
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R11
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_result) && $stable(out_carry)); // R11
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_zero == (out_result == '0))); // R12
  AST_LZC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 3'd0 && in_src == '0) |=>
      (out_result == XLEN'(XLEN) && out_carry)); // R1
  AST_TZC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 3'd1 && in_src == '0) |=>
      (out_result == XLEN'(XLEN) && out_carry)); // R2
  AST_POP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 3'd2) |=>
      (out_result == XLEN'($countones($past(in_src))) && !out_carry)); // R3
  AST_ISO_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 3'd4) |=> $onehot0(out_result)); // R6
  AST_CLR_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 3'd6 && in_src != '0) |=>
      ($countones(out_result) == $countones($past(in_src)) - 1)); // R8
  AST_ZHI_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 3'd7 && int'(in_ctl[7:0]) >= int'(XLEN)) |=>
      (out_result == $past(in_src) && out_carry)); // R10
endmodule

bind bitmanip_unit bmu_checker #(.XLEN(XLEN)) u_bmu_checker (
  .clk(clk), .rst_n(rst_sync_n), .in_valid(in_valid), .in_op(in_op),
  .in_src(in_src), .in_ctl(in_ctl), .out_valid(out_valid),
  .out_result(out_result), .out_carry(out_carry), .out_zero(out_zero)
);

// File: tb/tb_bitmanip_unit.sv
module tb_bitmanip_unit;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [2:0]   in_op;
  logic [W-1:0] in_src;
  logic [W-1:0] in_ctl;
  logic         out_valid;
  logic [W-1:0] out_result;
  logic         out_carry;
  logic         out_zero;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  bitmanip_unit #(.XLEN(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_src(in_src), .in_ctl(in_ctl), .out_valid(out_valid),
    .out_result(out_result), .out_carry(out_carry), .out_zero(out_zero)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Reference model, written from the requirements: returns {carry, result}
  function automatic logic [W:0] model(input logic [2:0] op,
                                       input logic [W-1:0] s,
                                       input logic [W-1:0] c);
    logic [W-1:0] r = '0;
    logic         cy = 1'b0;
    int           k, st, ln;
    st = int'(c[7:0]);
    ln = int'(c[15:8]);
    case (op)
      3'd0: begin
        k = W - 1;
        while (k >= 0 && !s[k]) k--;
        r = W'(W - 1 - k);
        cy = (s == '0);
      end
      3'd1: begin
        k = 0;
        while (k < W && !s[k]) k++;
        r = W'(k);
        cy = (s == '0);
      end
      3'd2: for (int i = 0; i < W; i++) r = r + W'(s[i]);
      3'd3: for (int i = 0; i < W; i++)
              if (i < ln && st + i < W) r[i] = s[st + i];
      3'd4, 3'd5, 3'd6: begin
        k = 0;
        while (k < W && !s[k]) k++;
        if (op == 3'd4) begin if (k < W) r[k] = 1'b1; end
        else if (op == 3'd5) begin
          for (int i = 0; i < W; i++) r[i] = (i <= k);
        end else begin
          r = s;
          if (k < W) r[k] = 1'b0;
        end
      end
      default: begin
        if (st >= W) begin r = s; cy = 1'b1; end
        else for (int i = 0; i < st; i++) r[i] = s[i];
      end
    endcase
    return {cy, r};
  endfunction

  task automatic apply(input logic [2:0] op, input logic [W-1:0] s,
                       input logic [W-1:0] c, input string req);
    logic [W:0] e;
    e = model(op, s, c);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_src = s; in_ctl = c;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, "valid",  64'(out_valid), 64'd1);
    check(req, "result", 64'(out_result), 64'(e[W-1:0]));
    check(req, "carry",  64'(out_carry), 64'(e[W]));
    check("R12", "zero", 64'(out_zero), 64'(e[W-1:0] == '0));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_src = '0; in_ctl = '0;
    repeat (3) @(negedge clk);
    check("R13", "valid",  64'(out_valid), 64'd0);
    check("R13", "result", 64'(out_result), 64'd0);
    check("R13", "carry",  64'(out_carry), 64'd0);
    check("R13", "zero",   64'(out_zero), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_counts();
    apply(3'd0, 32'h0001_0000, '0, "R1");
    apply(3'd0, 32'h8000_0000, '0, "R1");
    apply(3'd0, 32'h0000_0001, '0, "R1");
    apply(3'd0, 32'h0,         '0, "R1");
    apply(3'd1, 32'h0001_0000, '0, "R2");
    apply(3'd1, 32'h8000_0000, '0, "R2");
    apply(3'd1, 32'h0000_0001, '0, "R2");
    apply(3'd1, 32'h0,         '0, "R2");
    apply(3'd2, 32'hF0F0_1234, '0, "R3");
    apply(3'd2, 32'hFFFF_FFFF, '0, "R3");
    apply(3'd2, 32'h0,         '0, "R3");
  endtask

  task automatic t_field();
    apply(3'd3, 32'hDEAD_BEEF, 32'h0000_0804, "R4");
    apply(3'd3, 32'hDEAD_BEEF, 32'h0000_101C, "R4");
    apply(3'd3, 32'hDEAD_BEEF, 32'h0000_FF00, "R4");
    apply(3'd3, 32'hDEAD_BEEF, 32'h0000_2001, "R4");
    apply(3'd3, 32'hDEAD_BEEF, 32'h0000_0010, "R5");
    apply(3'd3, 32'hDEAD_BEEF, 32'h0000_0820, "R5");
    apply(3'd3, 32'hDEAD_BEEF, 32'h0000_08C8, "R5");
  endtask

  task automatic t_lowbit();
    apply(3'd4, 32'h0000_5A00, '0, "R6");
    apply(3'd4, 32'h8000_0000, '0, "R6");
    apply(3'd4, 32'h0,         '0, "R6");
    apply(3'd5, 32'h0000_5A00, '0, "R7");
    apply(3'd5, 32'h0000_0001, '0, "R7");
    apply(3'd5, 32'h8000_0000, '0, "R7");
    apply(3'd5, 32'h0,         '0, "R7");
    apply(3'd6, 32'h0000_5A00, '0, "R8");
    apply(3'd6, 32'h8000_0000, '0, "R8");
    apply(3'd6, 32'h0,         '0, "R8");
  endtask

  task automatic t_zhi();
    apply(3'd7, 32'hCAFE_F00D, 32'h0000_000C, "R9");
    apply(3'd7, 32'hCAFE_F00D, 32'h0000_001F, "R9");
    apply(3'd7, 32'hCAFE_F00D, 32'h0000_0000, "R9");
    apply(3'd7, 32'hCAFE_F00D, 32'h0000_0020, "R10");
    apply(3'd7, 32'hCAFE_F00D, 32'h0000_00FF, "R10");
  endtask

  task automatic t_hold();
    apply(3'd0, 32'h0, '0, "R11");
    @(negedge clk);
    in_op = 3'd2; in_src = 32'hFFFF_FFFF;
    @(negedge clk);
    check("R11", "idle valid",  64'(out_valid), 64'd0);
    check("R11", "idle result", 64'(out_result), 64'd32);
    check("R11", "idle carry",  64'(out_carry), 64'd1);
  endtask

  initial begin
    t_reset();
    t_counts();
    t_field();
    t_lowbit();
    t_zhi();
    t_hold();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule